// File: doc/BRIEF.md
# Temperature Event Configuration Controller

This block holds the configuration and limit registers of a temperature monitor and produces its event output. A host writes and reads the registers through a simple synchronous register port with an address, write data, a write strobe and combinational read data. A temperature converter outside the block delivers a signed reading with a one-cycle valid strobe. The block compares the latest reading against an upper limit, a lower limit and a critical limit. It then drives a single event pin whose polarity and enable are programmable.

Two sticky lock bits protect the settings. One lock guards the critical limit and the other guards the upper and lower limits. Either lock also freezes the event-control bits. A lock is set with one write and clears only through reset, which stands in for power-on reset. The event logic runs in comparator mode, where the event follows the comparison, or in interrupt mode, where the event latches and is released by writing a clear bit that is never stored.

Register map (2-bit address): 0 = configuration, 1 = upper limit, 2 = lower limit, 3 = critical limit. Configuration bits: 7 critical lock, 6 window lock, 5 clear event (write only), 4 event status (read only), 3 output enable, 2 critical-only select, 1 polarity (1 = active high), 0 mode (1 = interrupt). Bits above 7 read 0.

Top module: `temp_event_ctrl`

## Requirements
- R1: Writing 1 to configuration bit 7 sets the critical lock in one write. It then reads 1, a later write of 0 does not clear it, and only reset clears it.
- R2: While the critical lock is set, writes to address 3 (critical limit) leave its read value unchanged.
- R3: Writing 1 to bit 6 sets the sticky window lock. While it is set, writes to address 1 (upper) and address 2 (lower) leave their read values unchanged.
- R4: Bit 5 always reads 0. Writing 1 to it clears a latched event in interrupt mode and has no effect in comparator mode.
- R5: Bit 4 reads 1 exactly when the event pin is at its asserted level. Writes to bit 4 are ignored.
- R6: Bits 3, 2, 1 and 0 keep their values while either lock is set. A write that sets a lock still updates them when no lock was set before it.
- R7: The window condition is a signed reading above upper or below lower. The critical condition is a signed reading above critical. With bit 2 = 1, only the critical condition counts.
- R8: In comparator mode (bit 0 = 0), the event equals the condition. It takes effect on the second rising edge after the reading's valid strobe or the register write.
- R9: In interrupt mode (bit 0 = 1), the event latches when the condition goes from false to true and holds until cleared through bit 5.
- R10: The pin equals bit 1 when the output is enabled and the event is active. Otherwise it equals the inverse of bit 1, which is the inactive level.
- R11: After reset, configuration and all limits read 0, the stored reading is 0, and the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| temp_valid | input | 1 | New temperature reading strobe |
| temp_value | input | DATA_W | Signed temperature reading |
| evt_pin | output | 1 | Event output at the programmed polarity |

## Verification
The embedded assertions check on every cycle that the locks stay set, that protected limits and control bits stay stable under a lock, and that comparator mode tracks the condition one cycle later. They also check that a new condition edge latches in interrupt mode, that a held event survives without a clear, and that a disabled output rests at its inactive level. The bench scenarios show what a single cycle cannot. These are the signed window and critical comparisons across random readings and limits, the clear bit's opposite effect in the two modes, the lock-setting write that still updates control bits, and the read-only and write-only bits observed through register reads.

// File: rtl/temp_event_pkg.sv
// Package: shared register addresses, configuration bit positions and the
// control-field type of the temperature event controller.
package temp_event_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CFG   = 2'd0;
    localparam logic [ADDR_W-1:0] A_UPPER = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOWER = 2'd2;
    localparam logic [ADDR_W-1:0] A_CRIT  = 2'd3;

    localparam int B_CRIT_LOCK = 7;
    localparam int B_WIN_LOCK  = 6;
    localparam int B_CLEAR     = 5;
    localparam int B_STATUS    = 4;
    localparam int B_ENABLE    = 3;
    localparam int B_CONLY     = 2;
    localparam int B_POL       = 1;
    localparam int B_MODE      = 0;

    typedef struct packed {
        logic en;     // event output enable
        logic conly;  // critical-only events
        logic pol;    // 1 = active high
        logic mode;   // 1 = interrupt, 0 = comparator
    } ctrl_t;
endpackage

// File: rtl/tev_regs.sv
// Module: tev_regs
// Holds the configuration register, the two sticky locks and the three
// signed limit registers. Decodes writes and muxes reads.
// Assumes: the write strobe is one cycle per write and rst_n is the only
// power-on reset; read data is combinational from the address.
module tev_regs
    import temp_event_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     status,
    output logic [DATA_W-1:0]        rdata,
    output ctrl_t                    ctrl,
    output logic signed [DATA_W-1:0] upper,
    output logic signed [DATA_W-1:0] lower,
    output logic signed [DATA_W-1:0] crit,
    output logic                     clr_pulse
);
    localparam int PAD_W = DATA_W - 8;

    logic crit_lock;
    logic win_lock;
    logic any_lock;

    assign any_lock = crit_lock | win_lock;

    // Register writes: locks only ever set, protected fields gated by locks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_lock <= 1'b0;
            win_lock  <= 1'b0;
            ctrl      <= '0;
            upper     <= '0;
            lower     <= '0;
            crit      <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CFG: begin
                    crit_lock <= crit_lock | wdata[B_CRIT_LOCK];
                    win_lock  <= win_lock  | wdata[B_WIN_LOCK];
                    if (!any_lock) begin
                        ctrl <= '{en:    wdata[B_ENABLE],
                                  conly: wdata[B_CONLY],
                                  pol:   wdata[B_POL],
                                  mode:  wdata[B_MODE]};
                    end
                end
                A_UPPER: if (!win_lock)  upper <= wdata;
                A_LOWER: if (!win_lock)  lower <= wdata;
                default: if (!crit_lock) crit  <= wdata;
            endcase
        end
    end

    // Clear-event strobe: only meaningful in interrupt mode.
    assign clr_pulse = wr_en && (addr == A_CFG) && wdata[B_CLEAR] && ctrl.mode;

    // Read mux: clear bit always reads 0, status comes from the event path.
    always_comb begin
        case (addr)
            A_CFG:   rdata = {{PAD_W{1'b0}}, crit_lock, win_lock, 1'b0, status,
                              ctrl.en, ctrl.conly, ctrl.pol, ctrl.mode};
            A_UPPER: rdata = upper;
            A_LOWER: rdata = lower;
            default: rdata = crit;
        endcase
    end

    p_crit_lock_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        crit_lock |=> crit_lock);
    p_crit_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        crit_lock |=> $stable(crit));
    p_win_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_lock |=> ($stable(upper) && $stable(lower) && win_lock));
    p_ctrl_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock |=> $stable(ctrl));
endmodule

// File: rtl/tev_compare.sv
// Module: tev_compare
// Captures each valid temperature reading and compares it, signed, with the
// limits. Produces the event condition, narrowed by the critical-only bit.
// Assumes: limits may change at any time; the condition follows them at once.
module tev_compare #(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     temp_valid,
    input  logic signed [DATA_W-1:0] temp_in,
    input  logic signed [DATA_W-1:0] upper,
    input  logic signed [DATA_W-1:0] lower,
    input  logic signed [DATA_W-1:0] crit,
    input  logic                     crit_only,
    output logic                     cond
);
    logic signed [DATA_W-1:0] temp_q;
    logic win_hit;
    logic crit_hit;

    // Holds the latest valid reading.
    always_ff @(posedge clk) begin
        if (!rst_n)          temp_q <= '0;
        else if (temp_valid) temp_q <= temp_in;
    end

    // Signed limit comparisons and condition select.
    always_comb begin
        win_hit  = (temp_q > upper) || (temp_q < lower);
        crit_hit = (temp_q > crit);
        cond     = crit_only ? crit_hit : (win_hit || crit_hit);
    end

    p_hold_reading_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_valid |=> $stable(temp_q));
endmodule

// File: rtl/tev_event.sv
// Module: tev_event
// Event state: follows the condition in comparator mode, latches on a rising
// condition in interrupt mode and releases on the clear strobe.
// Assumes: clr is only raised in interrupt mode.
module tev_event (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic mode,
    input  logic clr,
    output logic evt
);
    logic prev_q;

    // Event state update per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            evt    <= 1'b0;
        end else begin
            prev_q <= cond;
            if (!mode) evt <= cond;
            else       evt <= (evt & ~clr) | (cond & ~prev_q);
        end
    end

    p_cmp_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> (evt == $past(cond)));
    p_int_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && cond && !prev_q) |=> evt);
    p_int_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && evt && !clr) |=> evt);
    p_clear_only_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> mode);
endmodule

// File: rtl/temp_event_ctrl.sv
// Module: temp_event_ctrl (top)
// Temperature event controller: configuration with sticky locks, limit
// registers, signed comparison and a programmable-polarity event pin.
// Assumes: rst_n is the power-on reset; the temperature source and register
// host share clk.
module temp_event_ctrl
    import temp_event_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              temp_valid,
    input  logic [DATA_W-1:0] temp_value,
    output logic              evt_pin
);
    ctrl_t                    ctrl;
    logic signed [DATA_W-1:0] upper;
    logic signed [DATA_W-1:0] lower;
    logic signed [DATA_W-1:0] crit;
    logic                     clr_pulse;
    logic                     cond;
    logic                     evt;
    logic                     asserted;

    tev_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .status(asserted), .rdata(reg_rdata),
        .ctrl(ctrl), .upper(upper), .lower(lower), .crit(crit),
        .clr_pulse(clr_pulse)
    );

    tev_compare #(.DATA_W(DATA_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid),
        .temp_in(temp_value), .upper(upper), .lower(lower), .crit(crit),
        .crit_only(ctrl.conly), .cond(cond)
    );

    tev_event u_evt (
        .clk(clk), .rst_n(rst_n), .cond(cond), .mode(ctrl.mode),
        .clr(clr_pulse), .evt(evt)
    );

    // Pin driver: asserted level equals the polarity bit, idle is its inverse.
    assign asserted = evt & ctrl.en;
    assign evt_pin  = ctrl.pol ? asserted : ~asserted;

    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (evt_pin == !ctrl.pol));
    p_status_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CFG) |-> (reg_rdata[B_CLEAR] == 1'b0));
endmodule

// File: tb/temp_event_ctrl_bench.sv
module temp_event_ctrl_bench;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          temp_valid = 1'b0;
    logic [DW-1:0] temp_value = '0;
    logic          evt_pin;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state, kept from the requirements.
    bit m_cl, m_wl, m_en, m_co, m_pol, m_mode, m_evt;
    logic signed [DW-1:0] m_up, m_lo, m_cr, m_t;

    temp_event_ctrl #(.DATA_W(DW)) u_temp_event_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .temp_valid(temp_valid), .temp_value(temp_value), .evt_pin(evt_pin)
    );

    always #2.5 clk = ~clk;

    function automatic bit cond_f();
        bit w, c;
        w = (m_t > m_up) || (m_t < m_lo);
        c = (m_t > m_cr);
        return m_co ? c : (w || c);
    endfunction

    function automatic logic [DW-1:0] cfg_f();
        return {8'h00, m_cl, m_wl, 1'b0, (m_evt & m_en), m_en, m_co, m_pol, m_mode};
    endfunction

    function automatic bit pin_f();
        return m_pol ? (m_evt & m_en) : ~(m_evt & m_en);
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk); @(posedge clk); @(negedge clk);
    endtask

    task automatic model_evt(bit old_c, bit clr);
        bit nc;
        nc = cond_f();
        if (!m_mode) m_evt = nc;
        else         m_evt = (m_evt & ~clr) | (nc & ~old_c);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; reg_wr = 1'b0; temp_valid = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        {m_cl, m_wl, m_en, m_co, m_pol, m_mode, m_evt} = '0;
        m_up = '0; m_lo = '0; m_cr = '0; m_t = '0;
    endtask

    task automatic wr(logic [1:0] a, logic [DW-1:0] d);
        bit oc, lk, clr;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
        oc = cond_f(); lk = m_cl | m_wl; clr = 1'b0;
        case (a)
            2'd0: begin
                clr = d[5] & m_mode;
                m_cl |= d[7]; m_wl |= d[6];
                if (!lk) {m_en, m_co, m_pol, m_mode} = d[3:0];
            end
            2'd1: if (!m_wl) m_up = d;
            2'd2: if (!m_wl) m_lo = d;
            default: if (!m_cl) m_cr = d;
        endcase
        model_evt(oc, clr);
        settle();
    endtask

    task automatic temp(logic signed [DW-1:0] t);
        bit oc;
        @(negedge clk);
        temp_valid = 1'b1; temp_value = t;
        @(posedge clk); @(negedge clk); temp_valid = 1'b0;
        oc = cond_f(); m_t = t;
        model_evt(oc, 1'b0);
        settle();
    endtask

    task automatic rd_check(string tag, logic [1:0] a, logic [DW-1:0] exp);
        reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic full_check(string tag);
        check({tag, " R10 pin"}, {15'd0, evt_pin}, {15'd0, pin_f()});
        rd_check({tag, " R5 R6 cfg"}, 2'd0, cfg_f());
        rd_check({tag, " R3 upper"}, 2'd1, m_up);
        rd_check({tag, " R3 lower"}, 2'd2, m_lo);
        rd_check({tag, " R2 crit"}, 2'd3, m_cr);
    endtask

    function automatic logic [DW-1:0] rnd_t();
        int v;
        v = int'($urandom_range(400)) - 200;
        return v[DW-1:0];
    endfunction

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        @(negedge clk);
        // R11: reset values
        rd_check("R11 cfg reset", 2'd0, 16'h0000);
        rd_check("R11 crit reset", 2'd3, 16'h0000);
        check("R11 pin reset", {15'd0, evt_pin}, 16'd1);

        // R7 R8: comparator, window and signed compare
        wr(2'd1, 16'd50); wr(2'd2, -16'sd20); wr(2'd3, 16'd90);
        wr(2'd0, 16'h000A);  // enable, active high, comparator
        temp(-16'sd25);
        check("R7 below lower signed", {15'd0, evt_pin}, 16'd1);
        temp(16'd10);
        check("R8 follows false", {15'd0, evt_pin}, 16'd0);
        // R7: critical-only ignores window
        wr(2'd0, 16'h000E);
        temp(16'd60);
        check("R7 crit-only window ignored", {15'd0, evt_pin}, 16'd0);
        temp(16'd95);
        check("R7 crit-only above crit", {15'd0, evt_pin}, 16'd1);
        // R4: clear in comparator mode has no effect
        wr(2'd0, 16'h002E);
        check("R4 clear comparator no effect", {15'd0, evt_pin}, 16'd1);
        rd_check("R4 clear reads 0 R5 status", 2'd0, 16'h001E);
        // R9: interrupt latch and clear
        wr(2'd0, 16'h000B);
        temp(16'd10);
        temp(16'd70);
        temp(16'd10);
        check("R9 latched after condition gone", {15'd0, evt_pin}, 16'd1);
        wr(2'd0, 16'h002B);
        check("R4 R9 clear in interrupt", {15'd0, evt_pin}, 16'd0);
        // R5: writes to status ignored; R10 active low
        wr(2'd0, 16'h0018);
        rd_check("R5 status write ignored", 2'd0, 16'h0008);
        check("R10 active low idle", {15'd0, evt_pin}, 16'd1);
        // R1 R6: lock write still updates controls, then freezes
        wr(2'd0, 16'h0089);
        rd_check("R1 R6 lock set with ctrl", 2'd0, cfg_f());
        wr(2'd0, 16'h0000);
        rd_check("R1 R6 lock sticky ctrl frozen", 2'd0, cfg_f());
        wr(2'd3, 16'd5);
        rd_check("R2 crit write ignored", 2'd3, 16'd90);
        wr(2'd1, 16'd1);
        rd_check("R3 upper writable without window lock", 2'd1, 16'd1);
        wr(2'd0, 16'h0040);
        wr(2'd2, 16'd7);
        rd_check("R3 lower write ignored", 2'd2, -16'sd20);
        do_reset(); @(negedge clk);
        rd_check("R1 R11 lock cleared by reset", 2'd0, 16'h0000);

        // Random rounds, each starting from reset.
        for (int r = 0; r < 4; r++) begin
            do_reset();
            for (int i = 0; i < 120; i++) begin
                int op;
                op = int'($urandom_range(9));
                if (op < 4)       temp(rnd_t());
                else if (op < 7)  wr(2'($urandom_range(1, 3)), rnd_t());
                else begin
                    logic [DW-1:0] d;
                    d = {8'h00, 8'($urandom)};
                    if ($urandom_range(15) != 0) d[7:6] = 2'b00;
                    wr(2'd0, d);
                end
                full_check("R7 R8 R9 random");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule